// File: doc/BRIEF.md
# Byte-Commanded I2C Bus Master

This block is an I2C master that software runs one byte at a time. A small register file holds a 16-bit clock divider split into two byte registers, an enable bit, a shared data register and a command register. A single write to the command register asks for any combination of a START condition, one byte written or read, the acknowledge level to return after a read, and a STOP condition. Software then polls the transfer-in-progress status bit until the byte has finished. It then loads the next byte and issues the next command. Both bus lines are open drain. The block only pulls them low or releases them, through active-low output-enable pins. The line inputs pass through a two-stage synchroniser before the block samples them or watches them for START and STOP.

The bit engine is a state machine with five states. `ST_IDLE` waits for a command. `ST_START` makes a START condition, or a repeated START when the master still holds SCL low. `ST_BIT` shifts eight bits out or in, MSB first. `ST_ACK` runs the ninth clock. `ST_STOP` makes a STOP condition.

Each state is four quarter-periods long, and each quarter lasts prescale+1 system clocks. The transitions are:
- `ST_IDLE` goes to `ST_START`, `ST_BIT` or `ST_STOP`, depending on the command bits.
- `ST_START` goes to `ST_BIT`, `ST_STOP` or `ST_IDLE`.
- `ST_BIT` goes to `ST_ACK` after its eighth bit.
- `ST_ACK` goes to `ST_STOP` if a stop was asked for, else to `ST_IDLE`. The master then keeps holding SCL low.
- `ST_STOP` goes to `ST_IDLE` and releases the bus.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, both output enables are 1 (lines released). The status register (index 4) and the control register (index 2) read 0x00, and both divider bytes (index 0 low, index 1 high) read 0xFF.
- R2: The divider bytes and the control register read back what was written. Control bit 7 is the enable bit and the other control bits read 0.
- R3: While control bit 7 is 0, a command write starts nothing. The status stays 0x00, both lines stay released and no START appears on the bus.
- R4: Every quarter-period lasts prescale+1 system clocks, so during a data or acknowledge clock SCL stays released for exactly 2×(prescale+1) clocks.
- R5: Command bit 7 produces a START, where SDA falls while SCL is high. Command bit 6 produces a STOP after the byte, where SDA rises while SCL is high. Status bit 6 reads 1 from a detected START until a detected STOP.
- R6: Command bit 4 sends the data register MSB first and samples the slave's answer on the ninth clock. Status bit 7 then reads 0 for ACK and 1 for NACK.
- R7: Command bit 5 shifts in one byte MSB first, which the data register (index 3) then returns. On the ninth clock the master drives SDA low when command bit 3 is 0 and releases SDA when it is 1.
- R8: Status bit 1 reads 1 from the cycle after a command is accepted until its byte, acknowledge and any STOP have finished. Commands written while it is 1 are ignored. The command index always reads as status, never as the written command.
- R9: A START issued while the master still owns the bus, without a STOP in between, produces a repeated START, so a write-address phase can be followed directly by a read-address phase.
- R10: Outside START and STOP, SDA changes only while SCL is low. After a STOP both lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register word index (byte address divided by 4) |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_n | output | 1 | 0 pulls SCL low, 1 releases it |
| sda_oe_n | output | 1 | 0 pulls SDA low, 1 releases it |

## Verification
A wrong quarter counter or divider reload shows up on the first SCL high pulse of a byte, as a pulse length other than 2×(prescale+1) clocks. A wrong bit counter or shift direction shows up at the ninth clock of that byte, as a byte in the slave model that does not match or a data register read that does not match. A state machine that leaves its busy state late, or never, holds status bit 1 high beyond the expected byte time, and the poll loop detects this. A bad START or STOP placement changes the START and STOP counts that the bench keeps from the line levels. A wrong ownership flag after an unstopped byte breaks the repeated START, which shows as a missing START or an extra STOP before the read phase.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    localparam int REG_AW  = 3;
    localparam int BYTE_W  = 8;
    localparam int DIV_W   = 16;

    localparam logic [REG_AW-1:0] IDX_DIV_LO = 3'd0;
    localparam logic [REG_AW-1:0] IDX_DIV_HI = 3'd1;
    localparam logic [REG_AW-1:0] IDX_CTRL   = 3'd2;
    localparam logic [REG_AW-1:0] IDX_DATA   = 3'd3;
    localparam logic [REG_AW-1:0] IDX_CMD    = 3'd4;

    localparam int CMD_STA  = 7;
    localparam int CMD_STO  = 6;
    localparam int CMD_RD   = 5;
    localparam int CMD_WR   = 4;
    localparam int CMD_NACK = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BIT,
        ST_ACK,
        ST_STOP
    } i2cm_state_e;
endpackage

// File: rtl/i2cm_linemon.sv
module i2cm_linemon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s_o,
    output logic bus_busy_o
);
    logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
    logic scl_prev, sda_prev, scl_s, start_det, stop_det;

    assign scl_s   = scl_sr[SYNC_STAGES-1];
    assign sda_s_o = sda_sr[SYNC_STAGES-1];

    assign start_det = scl_s && scl_prev && sda_prev && !sda_s_o;
    assign stop_det  = scl_s && scl_prev && !sda_prev && sda_s_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sr     <= '1;
            sda_sr     <= '1;
            scl_prev   <= 1'b1;
            sda_prev   <= 1'b1;
            bus_busy_o <= 1'b0;
        end else begin
            scl_sr   <= {scl_sr[SYNC_STAGES-2:0], scl_i};
            sda_sr   <= {sda_sr[SYNC_STAGES-2:0], sda_i};
            scl_prev <= scl_s;
            sda_prev <= sda_s_o;
            if (start_det)
                bus_busy_o <= 1'b1;
            else if (stop_det)
                bus_busy_o <= 1'b0;
        end
    end
endmodule

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '1;
        else if (!run_i || tick_o)
            cnt_q <= div_i;
        else
            cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/i2cm_fsm.sv
module i2cm_fsm
    import i2cm_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         go_i,
    input  logic         cmd_sta_i,
    input  logic         cmd_sto_i,
    input  logic         cmd_rd_i,
    input  logic         cmd_wr_i,
    input  logic         cmd_nack_i,
    input  logic [W-1:0] txd_i,
    input  logic         sda_s_i,
    output logic         tip_o,
    output logic         scl_rel_o,
    output logic         sda_rel_o,
    output logic         ack_rx_o,
    output logic [W-1:0] rxd_o
);
    localparam int BW = $clog2(W);

    i2cm_state_e   st_q;
    logic [1:0]    q_q;
    logic [BW-1:0] bit_q;
    logic [W-1:0]  tx_q, rx_q;
    logic          f_sto, f_rd, f_wr, f_nack, owned_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            q_q      <= 2'd0;
            bit_q    <= '1;
            tx_q     <= '0;
            rx_q     <= '0;
            rxd_o    <= '0;
            ack_rx_o <= 1'b0;
            owned_q  <= 1'b0;
            f_sto    <= 1'b0;
            f_rd     <= 1'b0;
            f_wr     <= 1'b0;
            f_nack   <= 1'b0;
        end else if (go_i && st_q == ST_IDLE) begin
            f_sto  <= cmd_sto_i;
            f_rd   <= cmd_rd_i;
            f_wr   <= cmd_wr_i;
            f_nack <= cmd_nack_i;
            tx_q   <= txd_i;
            bit_q  <= '1;
            q_q    <= 2'd0;
            if (cmd_sta_i)                  st_q <= ST_START;
            else if (cmd_rd_i || cmd_wr_i)  st_q <= ST_BIT;
            else if (cmd_sto_i)             st_q <= ST_STOP;
        end else if (tick_i && st_q != ST_IDLE) begin
            q_q <= q_q + 2'd1;
            unique case (st_q)
                ST_START: if (q_q == 2'd3) begin
                    owned_q <= 1'b1;
                    if (f_rd || f_wr)  st_q <= ST_BIT;
                    else if (f_sto)    st_q <= ST_STOP;
                    else               st_q <= ST_IDLE;
                end
                ST_BIT: begin
                    if (q_q == 2'd2)
                        rx_q <= {rx_q[W-2:0], sda_s_i};
                    if (q_q == 2'd3) begin
                        tx_q  <= {tx_q[W-2:0], 1'b0};
                        bit_q <= bit_q - 1'b1;
                        if (bit_q == '0)
                            st_q <= ST_ACK;
                    end
                end
                ST_ACK: begin
                    if (q_q == 2'd2 && f_wr)
                        ack_rx_o <= sda_s_i;
                    if (q_q == 2'd3) begin
                        if (f_rd)
                            rxd_o <= rx_q;
                        st_q <= f_sto ? ST_STOP : ST_IDLE;
                    end
                end
                ST_STOP: if (q_q == 2'd3) begin
                    owned_q <= 1'b0;
                    st_q    <= ST_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        tip_o = (st_q != ST_IDLE);
        unique case (st_q)
            ST_START: begin
                scl_rel_o = (q_q == 2'd0) ? !owned_q : (q_q != 2'd3);
                sda_rel_o = (q_q < 2'd2);
            end
            ST_BIT: begin
                scl_rel_o = (q_q == 2'd1) || (q_q == 2'd2);
                sda_rel_o = f_rd || tx_q[W-1];
            end
            ST_ACK: begin
                scl_rel_o = (q_q == 2'd1) || (q_q == 2'd2);
                sda_rel_o = f_wr || f_nack;
            end
            ST_STOP: begin
                scl_rel_o = (q_q != 2'd0);
                sda_rel_o = (q_q >= 2'd2);
            end
            default: begin
                scl_rel_o = !owned_q;
                sda_rel_o = 1'b1;
            end
        endcase
    end

    AST_BUSY_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tip_o) |-> $past(go_i)); // R8
    AST_PHASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q != $past(q_q)) |-> $past(tick_i)); // R4
    AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_BIT || st_q == ST_ACK) && scl_rel_o && $past(scl_rel_o))
        |-> $stable(sda_rel_o)); // R10
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2cm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe_n,
    output logic              sda_oe_n
);
    localparam int HALF = DIV_W / 2;

    logic [DIV_W-1:0]  div_q;
    logic              en_q;
    logic [BYTE_W-1:0] txd_q, rxd;
    logic              go, tick, tip, ack_rx, bus_busy, sda_s, scl_rel, sda_rel;
    logic [BYTE_W-1:0] status;
    logic              unused_wbits;

    assign unused_wbits = ^{reg_wdata[2:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '1;
            en_q  <= 1'b0;
            txd_q <= '0;
        end else if (reg_wr) begin
            unique case (reg_addr)
                IDX_DIV_LO: div_q[HALF-1:0]     <= reg_wdata;
                IDX_DIV_HI: div_q[DIV_W-1:HALF] <= reg_wdata;
                IDX_CTRL:   en_q                <= reg_wdata[7];
                IDX_DATA:   txd_q               <= reg_wdata;
                default: ;
            endcase
        end
    end

    assign go     = reg_wr && (reg_addr == IDX_CMD) && en_q && !tip;
    assign status = {ack_rx, bus_busy, 4'b0000, tip, 1'b0};

    always_comb begin
        unique case (reg_addr)
            IDX_DIV_LO: reg_rdata = div_q[HALF-1:0];
            IDX_DIV_HI: reg_rdata = div_q[DIV_W-1:HALF];
            IDX_CTRL:   reg_rdata = {en_q, 7'b0};
            IDX_DATA:   reg_rdata = rxd;
            IDX_CMD:    reg_rdata = status;
            default:    reg_rdata = '0;
        endcase
    end

    i2cm_linemon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s_o(sda_s), .bus_busy_o(bus_busy)
    );

    i2cm_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run_i(tip), .div_i(div_q), .tick_o(tick)
    );

    i2cm_fsm #(.W(BYTE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .go_i(go),
        .cmd_sta_i(reg_wdata[CMD_STA]), .cmd_sto_i(reg_wdata[CMD_STO]),
        .cmd_rd_i(reg_wdata[CMD_RD]), .cmd_wr_i(reg_wdata[CMD_WR]),
        .cmd_nack_i(reg_wdata[CMD_NACK]), .txd_i(txd_q), .sda_s_i(sda_s),
        .tip_o(tip), .scl_rel_o(scl_rel), .sda_rel_o(sda_rel),
        .ack_rx_o(ack_rx), .rxd_o(rxd)
    );

    assign scl_oe_n = scl_rel;
    assign sda_oe_n = sda_rel;

    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !$rose(tip)); // R3
endmodule

// File: tb/i2c_byte_master_tb_top.sv
`timescale 1ns/1ps
module i2c_byte_master_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic scl_oe_n, sda_oe_n;
    logic s_drv = 1'b0;
    logic nack_mode = 1'b0;
    wire scl_line = scl_oe_n;
    wire sda_line = sda_oe_n & ~s_drv;

    int n_cmp = 0, n_bad = 0;
    always #2 clk = ~clk;

    i2c_byte_master dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_i(scl_line),
        .sda_i(sda_line), .scl_oe_n(scl_oe_n), .sda_oe_n(sda_oe_n)
    );

    // slave model and bus monitor
    logic [7:0] rd_src [16];
    logic [7:0] rx_log [64];
    logic       mack_log [64];
    int rx_n = 0, mack_n = 0, n_start = 0, n_stop = 0, rd_idx = 0, s_bitc = 0;
    logic [7:0] s_byte = '0, last_addr = '0;
    logic prev_scl = 1'b1, prev_sda = 1'b1, s_rdmode = 1'b0, s_addrb = 1'b0, s_done = 1'b0;

    always @(scl_line, sda_line) begin
        if (scl_line && prev_scl && prev_sda && !sda_line) begin
            n_start++; s_bitc = 0; s_addrb = 1; s_rdmode = 0; s_done = 0; s_drv = 0;
        end else if (scl_line && prev_scl && !prev_sda && sda_line) begin
            n_stop++; s_rdmode = 0; s_drv = 0;
        end else if (scl_line && !prev_scl) begin
            if (s_bitc < 8) begin
                s_byte = {s_byte[6:0], sda_line};
                s_bitc++;
                if (s_bitc == 8) begin
                    if (s_addrb) begin last_addr = s_byte; s_rdmode = s_byte[0]; end
                    else if (!s_rdmode) begin rx_log[rx_n] = s_byte; rx_n++; end
                end
            end else begin
                if (s_rdmode && !s_addrb) begin
                    mack_log[mack_n] = sda_line; mack_n++;
                    if (sda_line) s_done = 1;
                    rd_idx++;
                end
                s_addrb = 0; s_bitc = 0;
            end
        end else if (!scl_line && prev_scl) begin
            if (s_bitc == 8 && (s_addrb || !s_rdmode)) s_drv = !nack_mode;
            else if (s_rdmode && !s_addrb && !s_done && s_bitc < 8)
                s_drv = !rd_src[rd_idx[3:0]][7 - s_bitc];
            else s_drv = 0;
        end
        prev_scl = scl_line; prev_sda = sda_line;
    end

    int hi_cnt = 0, hi_len = 0;
    always @(negedge clk) begin
        if (scl_line) hi_cnt++;
        else if (hi_cnt != 0) begin hi_len = hi_cnt; hi_cnt = 0; end
    end

    function automatic logic [7:0] exp_status(input logic nack, input logic bb, input logic tip);
        return {nack, bb, 4'b0000, tip, 1'b0};
    endfunction
    function automatic int exp_high(input int pre);
        return 2 * (pre + 1);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask
    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask
    task automatic wait_idle(input string tag);
        logic [7:0] v;
        int guard = 0;
        do begin rd(3'd4, v); guard++; end while (v[1] && guard < 20000);
        chk({tag, " completes"}, v[1], 0);
    endtask
    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] v, d;
        int pre, b_start, b_stop, b_rx, e_idx;
        void'($urandom(32'h5A17));
        for (int i = 0; i < 16; i++) rd_src[i] = 8'($urandom);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 scl_oe_n", scl_oe_n, 1);
        chk("R1 sda_oe_n", sda_oe_n, 1);
        rd(3'd4, v); chk("R1 status", v, 8'h00);
        rd(3'd2, v); chk("R1 ctrl", v, 8'h00);
        rd(3'd0, v); chk("R1 div lo", v, 8'hFF);
        rd(3'd1, v); chk("R1 div hi", v, 8'hFF);
        // R3 commands ignored while disabled
        b_start = n_start;
        wr(3'd3, 8'hA0); wr(3'd4, 8'h90);
        repeat (60) @(negedge clk);
        rd(3'd4, v); chk("R3 status", v, 8'h00);
        chk("R3 lines", {scl_oe_n, sda_oe_n}, 2'b11);
        chk("R3 starts", n_start - b_start, 0);
        // R2 readback
        d = 8'($urandom); wr(3'd1, d); rd(3'd1, v); chk("R2 div hi", v, d);
        wr(3'd1, 8'h00);
        pre = 1 + int'($urandom % 5);
        wr(3'd0, 8'(pre)); rd(3'd0, v); chk("R2 div lo", v, 8'(pre));
        wr(3'd2, 8'hFF); rd(3'd2, v); chk("R2 ctrl", v, 8'h80);
        // R5 R6 R8 address write
        b_start = n_start; b_stop = n_stop; b_rx = rx_n;
        wr(3'd3, 8'hA0); wr(3'd4, 8'h90);
        rd(3'd4, v); chk("R8 tip set", v[1], 1);
        wr(3'd4, 8'h50); // R8 ignored while busy
        wait_idle("R8 addr");
        chk("R6 addr byte", last_addr, 8'hA0);
        chk("R5 start seen", n_start - b_start, 1);
        rd(3'd4, v); chk("R5 R6 status after addr", v, exp_status(0, 1, 0));
        for (int k = 0; k < 4; k++) begin
            pre = 1 + int'($urandom % 5);
            wr(3'd0, 8'(pre));
            d = 8'($urandom);
            wr(3'd3, d); wr(3'd4, (k == 3) ? 8'h50 : 8'h10);
            wait_idle("R6 data");
            chk("R6 byte", rx_log[rx_n - 1], d);
            if (k < 3) chk("R4 scl high clocks", hi_len, exp_high(pre));
        end
        chk("R8 busy cmd ignored", rx_n - b_rx, 4);
        chk("R5 stop seen", n_stop - b_stop, 1);
        rd(3'd4, v); chk("R5 status after stop", v, exp_status(0, 0, 0));
        chk("R10 released after stop", {scl_oe_n, sda_oe_n}, 2'b11);
        // R6 NACK from slave
        nack_mode = 1'b1;
        wr(3'd3, 8'hA0); wr(3'd4, 8'h90); wait_idle("R6 nack");
        rd(3'd4, v); chk("R6 nack status", v, exp_status(1, 1, 0));
        wr(3'd4, 8'h40); wait_idle("R5 lone stop");
        nack_mode = 1'b0;
        rd(3'd4, v); chk("R5 stop status", v, exp_status(1, 0, 0));
        // R9 repeated start then R7 reads
        b_start = n_start; b_stop = n_stop; e_idx = rd_idx;
        wr(3'd3, 8'hA0); wr(3'd4, 8'h90); wait_idle("R9 wr addr");
        wr(3'd3, 8'h07); wr(3'd4, 8'h10); wait_idle("R9 reg byte");
        wr(3'd3, 8'hA1); wr(3'd4, 8'h90); wait_idle("R9 rd addr");
        chk("R9 two starts", n_start - b_start, 2);
        chk("R9 no stop", n_stop - b_stop, 0);
        chk("R9 read address", last_addr, 8'hA1);
        for (int k = 0; k < 4; k++) begin
            wr(3'd4, (k == 3) ? 8'h68 : 8'h20);
            wait_idle("R7 read");
            rd(3'd3, v); chk("R7 read byte", v, rd_src[e_idx[3:0]]);
            chk("R7 master ack level", mack_log[mack_n - 1], (k == 3) ? 1 : 0);
            e_idx++;
        end
        chk("R7 stop after last read", n_stop - b_stop, 1);
        rd(3'd4, v); chk("R8 cmd index reads status", v[6:1], 6'b000000);
        chk("R10 lines free", {scl_oe_n, sda_oe_n}, 2'b11);
        finish_run();
    end
endmodule